// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which clock domains of a small microcontroller may run. It sits beside the CPU and takes its mode requests: back to full speed, into a reduced-speed mode, into wait-for-interrupt, into halt or into stop. It also watches an interrupt-acknowledge input, an external wake-up line and the watchdog's enable status. From these it drives three clock enables, a clock-divider select and a watchdog run/freeze control. The enables cover the CPU, the general peripherals, and the interrupt controller together with the peripherals that can raise interrupts. It also reports the current mode as a code. The clock gates, the divider, the oscillator and the watchdog counter are outside the block and see only these enables.

Each low-power mode has its own way out. An acknowledged interrupt ends wait-for-interrupt. Only a system reset ends halt, and an enabled watchdog blocks entry into halt. The wake-up line ends stop, and stop then runs an oscillator settling count before any clock comes back. Stop and the settling count hold the watchdog frozen, so it carries on from its held value afterwards. Leaving wait or stop returns the CPU to whichever of full or reduced speed it came from, with no reset.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset (`rstN` low, asynchronous) is asserted and in the first cycle after it, the mode code is 0 (run). All three clock enables are 1, `clkDivSel` is 0, `startupBusy` is 0 and `oscStable` is 1.
- R2: In run or slow, `reqSlow` moves the block to slow (mode code 1) on the next clock edge. `reqRun` moves it to run. In slow all three enables are 1 and `clkDivSel` follows `slowDiv`. In run `clkDivSel` is 0.
- R3: In run or slow, `reqWfi` enters wait-for-interrupt (mode code 2). There `cpuClkEn` and `perClkEn` are 0, `irqClkEn` is 1 and `clkDivSel` follows `wfiDiv`. `irqAck` returns the block on the next edge to the mode it left, run or slow.
- R4: A halt request while `wdogEn` is 1 is treated as absent. The block stays in its current mode.
- R5: In halt (mode code 3) all three enables are 0 and `clkDivSel` is 0. Requests, `irqAck` and `wakeUp` have no effect. Only reset leaves halt, and it leaves to run.
- R6: `reqStop` in run or slow enters stop (mode code 4) with all enables 0 and `oscStable` cleared. `wakeUp` in stop starts the settling count on the next edge. `irqAck` in stop has no effect.
- R7: `wdogRun` equals `wdogEn` except while in stop or during the settling count, when it is 0.
- R8: The settling count holds `startupBusy` at 1 for exactly `STARTUP_CYC` cycles. During it the mode code stays 4 and all enables are 0. On the edge that ends it, `oscStable` returns to 1 and the block returns to the run or slow mode held before stop.
- R9: Mode requests made in wait, halt, stop or during the settling count are ignored.
- R10: Requests made in the same cycle are served in the order stop, halt, wait, slow, run. A vetoed halt counts as absent.
- R11: The mode code is run=0, slow=1, wait=2, halt=3, stop=4. `startupBusy` marks the settling count separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rstN | input | 1 | System reset, active low |
| reqRun | input | 1 | Request full-speed run |
| reqSlow | input | 1 | Request reduced-speed mode |
| reqWfi | input | 1 | Request wait-for-interrupt |
| reqHalt | input | 1 | Request halt |
| reqStop | input | 1 | Request stop |
| slowDiv | input | DIV_W | Divider select used in slow |
| wfiDiv | input | DIV_W | Divider select used in wait |
| irqAck | input | 1 | Interrupt request acknowledged |
| wakeUp | input | 1 | External wake-up line |
| wdogEn | input | 1 | Watchdog is enabled |
| cpuClkEn | output | 1 | CPU clock enable |
| perClkEn | output | 1 | General peripheral clock enable |
| irqClkEn | output | 1 | Interrupt controller and interrupt-capable peripheral clock enable |
| clkDivSel | output | DIV_W | Divider select for the enabled clocks |
| wdogRun | output | 1 | Watchdog counts when 1, holds its value when 0 |
| modeCode | output | 3 | Current mode code |
| startupBusy | output | 1 | Oscillator settling count in progress |
| oscStable | output | 1 | Oscillator is considered settled |

## Verification
The bench builds the block with `STARTUP_CYC` = 8 and `DIV_W` = 3. The short settling count lets the bench watch the whole wake-up window edge by edge, including the exact cycle `startupBusy` falls and the ignored requests inside it. Three divider bits give distinct slow and wait divider values, so a wrong selection shows at the port.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    MODE_RUN  = 3'd0,
    MODE_SLOW = 3'd1,
    MODE_WFI  = 3'd2,
    MODE_HALT = 3'd3,
    MODE_STOP = 3'd4
  } modeE;

  typedef enum logic [2:0] {
    SQ_RUN  = 3'd0,
    SQ_SLOW = 3'd1,
    SQ_WFI  = 3'd2,
    SQ_HALT = 3'd3,
    SQ_STOP = 3'd4,
    SQ_WAKE = 3'd5
  } seqStateE;

  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic stableDrop;
    logic stableRise;
  } dpStrobeT;

endpackage

// File: rtl/pms_ctrl.sv
module pms_ctrl
  import pms_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqRun,
  input  logic     reqSlow,
  input  logic     reqWfi,
  input  logic     reqHalt,
  input  logic     reqStop,
  input  logic     irqAck,
  input  logic     wakeUp,
  input  logic     wdogEn,
  input  logic     cntDone,
  output modeE     modeOut,
  output logic     waking,
  output dpStrobeT strobe
);

  seqStateE curState, nxtState;
  logic     prevSlow, nxtPrevSlow;
  logic     activeMode;
  logic     haltOk;

  assign activeMode = (curState == SQ_RUN) || (curState == SQ_SLOW);
  assign haltOk     = reqHalt && !wdogEn;

  always_comb begin
    nxtState    = curState;
    nxtPrevSlow = prevSlow;
    strobe      = '0;
    unique case (curState)
      SQ_RUN, SQ_SLOW: begin
        if (reqStop) begin
          nxtState          = SQ_STOP;
          nxtPrevSlow       = (curState == SQ_SLOW);
          strobe.stableDrop = 1'b1;
        end else if (haltOk) begin
          nxtState = SQ_HALT;
        end else if (reqWfi) begin
          nxtState    = SQ_WFI;
          nxtPrevSlow = (curState == SQ_SLOW);
        end else if (reqSlow) begin
          nxtState = SQ_SLOW;
        end else if (reqRun) begin
          nxtState = SQ_RUN;
        end
      end
      SQ_WFI: begin
        if (irqAck) nxtState = prevSlow ? SQ_SLOW : SQ_RUN;
      end
      SQ_HALT: nxtState = SQ_HALT;
      SQ_STOP: begin
        if (wakeUp) begin
          nxtState        = SQ_WAKE;
          strobe.cntClear = 1'b1;
        end
      end
      SQ_WAKE: begin
        strobe.cntStep = 1'b1;
        if (cntDone) begin
          nxtState          = prevSlow ? SQ_SLOW : SQ_RUN;
          strobe.stableRise = 1'b1;
        end
      end
      default: nxtState = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= SQ_RUN;
      prevSlow <= 1'b0;
    end else begin
      curState <= nxtState;
      prevSlow <= nxtPrevSlow;
    end
  end

  always_comb begin
    unique case (curState)
      SQ_RUN:  modeOut = MODE_RUN;
      SQ_SLOW: modeOut = MODE_SLOW;
      SQ_WFI:  modeOut = MODE_WFI;
      SQ_HALT: modeOut = MODE_HALT;
      default: modeOut = MODE_STOP;
    endcase
  end

  assign waking = (curState == SQ_WAKE);

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (curState == SQ_HALT) |=> (curState == SQ_HALT)); // R5

  AST_HALT_VETO: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode && wdogEn && !reqStop) |=> (curState != SQ_HALT)); // R4

  AST_WFI_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (curState == SQ_WFI && irqAck) |=> (curState == (prevSlow ? SQ_SLOW : SQ_RUN))); // R3

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (curState == SQ_STOP && !wakeUp) |=> (curState == SQ_STOP)); // R9

  AST_WAKE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (curState == SQ_STOP && wakeUp) |=> (curState == SQ_WAKE)); // R6

endmodule

// File: rtl/pms_dpath.sv
module pms_dpath
  import pms_pkg::*;
#(
  parameter int STARTUP_CYC = 4096,
  parameter int DIV_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strobe,
  input  modeE             modeIn,
  input  logic             waking,
  input  logic             wdogEn,
  input  logic [DIV_W-1:0] slowDiv,
  input  logic [DIV_W-1:0] wfiDiv,
  output logic             cntDone,
  output logic             cpuClkEn,
  output logic             perClkEn,
  output logic             irqClkEn,
  output logic [DIV_W-1:0] clkDivSel,
  output logic             wdogRun,
  output logic             oscStable
);

  localparam int CW = $clog2(STARTUP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CYC - 1);

  logic [CW-1:0] settleCnt;

  assign cntDone = (settleCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strobe.cntClear) begin
      settleCnt <= '0;
    end else if (strobe.cntStep && !cntDone) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscStable <= 1'b1;
    end else if (strobe.stableDrop) begin
      oscStable <= 1'b0;
    end else if (strobe.stableRise) begin
      oscStable <= 1'b1;
    end
  end

  always_comb begin
    cpuClkEn  = 1'b0;
    perClkEn  = 1'b0;
    irqClkEn  = 1'b0;
    clkDivSel = '0;
    unique case (modeIn)
      MODE_RUN: begin
        cpuClkEn = 1'b1;
        perClkEn = 1'b1;
        irqClkEn = 1'b1;
      end
      MODE_SLOW: begin
        cpuClkEn  = 1'b1;
        perClkEn  = 1'b1;
        irqClkEn  = 1'b1;
        clkDivSel = slowDiv;
      end
      MODE_WFI: begin
        irqClkEn  = 1'b1;
        clkDivSel = wfiDiv;
      end
      default: ;
    endcase
  end

  assign wdogRun = wdogEn && (modeIn != MODE_STOP);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (settleCnt <= LAST)); // R8

  AST_NO_CLK_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    waking |-> (!cpuClkEn && !perClkEn && !irqClkEn)); // R8

  AST_UNSTABLE_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    waking |-> !oscStable); // R6

  AST_WDOG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    waking |-> !wdogRun); // R7

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int STARTUP_CYC = 4096,
  parameter int DIV_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqRun,
  input  logic             reqSlow,
  input  logic             reqWfi,
  input  logic             reqHalt,
  input  logic             reqStop,
  input  logic [DIV_W-1:0] slowDiv,
  input  logic [DIV_W-1:0] wfiDiv,
  input  logic             irqAck,
  input  logic             wakeUp,
  input  logic             wdogEn,
  output logic             cpuClkEn,
  output logic             perClkEn,
  output logic             irqClkEn,
  output logic [DIV_W-1:0] clkDivSel,
  output logic             wdogRun,
  output logic [2:0]       modeCode,
  output logic             startupBusy,
  output logic             oscStable
);

  dpStrobeT strobe;
  modeE     modeNow;
  logic     waking;
  logic     cntDone;

  pms_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqRun  (reqRun),
    .reqSlow (reqSlow),
    .reqWfi  (reqWfi),
    .reqHalt (reqHalt),
    .reqStop (reqStop),
    .irqAck  (irqAck),
    .wakeUp  (wakeUp),
    .wdogEn  (wdogEn),
    .cntDone (cntDone),
    .modeOut (modeNow),
    .waking  (waking),
    .strobe  (strobe)
  );

  pms_dpath #(
    .STARTUP_CYC (STARTUP_CYC),
    .DIV_W       (DIV_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .modeIn    (modeNow),
    .waking    (waking),
    .wdogEn    (wdogEn),
    .slowDiv   (slowDiv),
    .wfiDiv    (wfiDiv),
    .cntDone   (cntDone),
    .cpuClkEn  (cpuClkEn),
    .perClkEn  (perClkEn),
    .irqClkEn  (irqClkEn),
    .clkDivSel (clkDivSel),
    .wdogRun   (wdogRun),
    .oscStable (oscStable)
  );

  assign modeCode    = modeNow;
  assign startupBusy = waking;

  AST_STOP_NO_CLK: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd4) |-> (!cpuClkEn && !perClkEn && !irqClkEn)); // R6

  AST_HALT_NO_CLK: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd3) |-> (!cpuClkEn && !perClkEn && !irqClkEn && clkDivSel == '0)); // R5

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode <= 3'd4) && (!startupBusy || modeCode == 3'd4)); // R11

endmodule

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;

  localparam int STARTUP_CYC = 8;
  localparam int DIV_W       = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqRun = 0, reqSlow = 0, reqWfi = 0, reqHalt = 0, reqStop = 0;
  logic [DIV_W-1:0] slowDiv = 3'd5;
  logic [DIV_W-1:0] wfiDiv  = 3'd6;
  logic irqAck = 0, wakeUp = 0, wdogEn = 0;
  logic cpuClkEn, perClkEn, irqClkEn, wdogRun, startupBusy, oscStable;
  logic [DIV_W-1:0] clkDivSel;
  logic [2:0] modeCode;

  int errs = 0;
  int checks = 0;
  int cycles = 0;
  string curReq = "R1";
  bit done = 0;

  // reference model state: 0..4 modes, 5 = settling
  int mState = 0;
  int mPrev = 0;
  int mCnt = 0;
  int mStable = 1;

  always #2 clk = ~clk;

  pwr_mode_seq #(.STARTUP_CYC(STARTUP_CYC), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rstN(rstN), .reqRun(reqRun), .reqSlow(reqSlow), .reqWfi(reqWfi),
    .reqHalt(reqHalt), .reqStop(reqStop), .slowDiv(slowDiv), .wfiDiv(wfiDiv),
    .irqAck(irqAck), .wakeUp(wakeUp), .wdogEn(wdogEn), .cpuClkEn(cpuClkEn),
    .perClkEn(perClkEn), .irqClkEn(irqClkEn), .clkDivSel(clkDivSel),
    .wdogRun(wdogRun), .modeCode(modeCode), .startupBusy(startupBusy),
    .oscStable(oscStable)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", curReq, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int eCpu, ePer, eIrq, eDiv, eWd, eCode, eBusy;
    eCpu = 0; ePer = 0; eIrq = 0; eDiv = 0;
    case (mState)
      0: begin eCpu = 1; ePer = 1; eIrq = 1; end
      1: begin eCpu = 1; ePer = 1; eIrq = 1; eDiv = slowDiv; end
      2: begin eIrq = 1; eDiv = wfiDiv; end
      default: ;
    endcase
    eCode = (mState == 5) ? 4 : mState;
    eBusy = (mState == 5) ? 1 : 0;
    eWd   = (wdogEn && mState != 4 && mState != 5) ? 1 : 0;
    chk("modeCode R11", modeCode, eCode);
    chk("cpuClkEn", cpuClkEn, eCpu);
    chk("perClkEn", perClkEn, ePer);
    chk("irqClkEn", irqClkEn, eIrq);
    chk("clkDivSel", clkDivSel, eDiv);
    chk("wdogRun R7", wdogRun, eWd);
    chk("startupBusy R8", startupBusy, eBusy);
    chk("oscStable", oscStable, mStable);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mState = 0; mPrev = 0; mCnt = 0; mStable = 1;
    end else begin
      case (mState)
        0, 1: begin
          if (reqStop) begin mPrev = mState; mState = 4; mStable = 0; end
          else if (reqHalt && !wdogEn) mState = 3;
          else if (reqWfi) begin mPrev = mState; mState = 2; end
          else if (reqSlow) mState = 1;
          else if (reqRun) mState = 0;
        end
        2: if (irqAck) mState = mPrev;
        4: if (wakeUp) begin mState = 5; mCnt = 0; end
        5: begin
          mCnt++;
          if (mCnt == STARTUP_CYC) begin mState = mPrev; mStable = 1; end
        end
        default: ;
      endcase
    end
    #1;
    if (!done) compareAll();
  end

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      finishRun();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one-cycle pulse on a chosen input set
  task automatic pulse(input bit r, input bit s, input bit w, input bit h, input bit p,
                       input bit ack, input bit wk);
    @(negedge clk);
    reqRun = r; reqSlow = s; reqWfi = w; reqHalt = h; reqStop = p; irqAck = ack; wakeUp = wk;
    @(negedge clk);
    reqRun = 0; reqSlow = 0; reqWfi = 0; reqHalt = 0; reqStop = 0; irqAck = 0; wakeUp = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    idle(2);
    rstN = 1;
  endtask

  initial begin
    curReq = "R1";
    idle(3);
    chk("reset modeCode R1", modeCode, 0);
    chk("reset cpuClkEn R1", cpuClkEn, 1);
    chk("reset oscStable R1", oscStable, 1);
    chk("reset startupBusy R1", startupBusy, 0);
    rstN = 1;
    idle(2);
    chk("post-reset clkDivSel R1", clkDivSel, 0);

    curReq = "R2";
    pulse(0, 1, 0, 0, 0, 0, 0); idle(2);
    slowDiv = 3'd3; idle(2);
    pulse(1, 0, 0, 0, 0, 0, 0); idle(2);
    pulse(0, 1, 0, 0, 0, 0, 0); idle(1);

    curReq = "R3";
    pulse(0, 0, 1, 0, 0, 0, 0); idle(3);
    wfiDiv = 3'd2; idle(1);
    curReq = "R9";
    pulse(1, 1, 0, 1, 1, 0, 1); idle(2);
    curReq = "R3";
    pulse(0, 0, 0, 0, 0, 1, 0); idle(2);
    pulse(1, 0, 0, 0, 0, 0, 0); idle(1);
    pulse(0, 0, 1, 0, 0, 0, 0); idle(2);
    pulse(0, 0, 0, 0, 0, 1, 0); idle(2);

    curReq = "R10";
    pulse(1, 1, 1, 0, 0, 0, 0); idle(2);
    pulse(0, 0, 0, 0, 0, 1, 0); idle(1);
    pulse(1, 1, 0, 0, 0, 0, 0); idle(1);
    pulse(1, 0, 0, 0, 0, 0, 0); idle(1);
    pulse(1, 0, 0, 0, 0, 0, 0); idle(1);

    curReq = "R4";
    wdogEn = 1;
    pulse(0, 0, 0, 1, 0, 0, 0); idle(2);
    pulse(0, 1, 0, 1, 0, 0, 0); idle(2);
    pulse(1, 0, 0, 0, 0, 0, 0); idle(1);

    curReq = "R6";
    pulse(0, 1, 0, 0, 0, 0, 0); idle(1);
    pulse(0, 0, 0, 0, 1, 0, 0); idle(3);
    pulse(0, 0, 0, 0, 0, 1, 0); idle(2);
    curReq = "R7";
    wdogEn = 0; idle(2); wdogEn = 1; idle(2);
    curReq = "R9";
    pulse(1, 1, 1, 0, 0, 0, 0); idle(2);
    curReq = "R8";
    pulse(0, 0, 0, 0, 0, 0, 1); idle(3);
    curReq = "R9";
    pulse(1, 0, 1, 1, 1, 1, 1); idle(2);
    curReq = "R8";
    idle(STARTUP_CYC + 3);

    curReq = "R10";
    pulse(0, 0, 1, 0, 1, 0, 0); idle(2);
    curReq = "R8";
    pulse(0, 0, 0, 0, 0, 0, 1); idle(STARTUP_CYC + 3);

    curReq = "R5";
    wdogEn = 0;
    pulse(0, 1, 1, 1, 0, 0, 0); idle(3);
    pulse(1, 1, 1, 1, 1, 1, 1); idle(3);
    wdogEn = 1; idle(2);
    chk("halt modeCode R5", modeCode, 3);
    curReq = "R1";
    doReset(); idle(2);
    chk("halt exit by reset R5", modeCode, 0);

    finishRun();
  end

endmodule